// File: doc/BRIEF.md
# Flash Block Write-Protection Unit

This unit keeps the write-protection state of a 32-megabit serial flash whose 4 MB address space is split into 64 blocks of 64 KB. A three-bit protect code chooses how much of the top of the array is shielded from program and erase. The shielded part can be nothing, the top 1, 2, 4, 8, 16 or 32 blocks, or the whole array. A lock bit can freeze that code, but only while the write-protect pin is held low.

The command decoder in front of the array sends three kinds of strobe:

- a status-write strobe with a data word;
- a program/erase strobe with a 22-bit byte address;
- a chip-erase strobe.

One clock after each program/erase or chip-erase strobe, the unit answers with a single-cycle grant or deny pulse. The decoder only touches the array on a grant. A blocked status write leaves every stored bit as it was and raises a one-cycle rejection flag.

Top module: `flash_wp_unit`

## Requirements
- R1: While reset (active-low `rst_n`) is asserted and right after it is released, `prot_code` reads 3'b111, `lock_bit` reads 0, and `pe_grant`, `pe_deny`, `ce_grant`, `ce_deny` and `sts_rej` are all 0.
- R2: The block number is `pe_addr[21:16]`. For a nonzero code c, blocks numbered 64 − 2^(c−1) and above are protected. Code 1 protects from 3F0000h, code 2 from 3E0000h, code 3 from 3C0000h, code 4 from 380000h, code 5 from 300000h and code 6 from 200000h. Addresses just below each boundary are not protected.
- R3: Each cycle with `pe_req` high gives exactly one of `pe_grant` or `pe_deny` high in the next cycle, for that cycle only. Without a request both stay low. Deny means the address is protected.
- R4: Code 3'b000 grants every address. Code 3'b111 denies every address, including 000000h.
- R5: A status write with `wp_pin` high, or with `lock_bit` at 0, is accepted. From the next cycle, `prot_code` equals `sts_wdata[2:0]` and `lock_bit` equals `sts_wdata[3]`.
- R6: A status write with `wp_pin` low and `lock_bit` at 1 changes neither `prot_code` nor `lock_bit`. It makes `sts_rej` high for exactly the next cycle.
- R7: With `wp_pin` high, a set `lock_bit` has no effect: the status write is accepted, `lock_bit` itself can be cleared, and `sts_rej` stays 0.
- R8: A `ce_req` gives `ce_grant` in the next cycle when `prot_code` is 3'b000, and `ce_deny` otherwise. Each is a one-cycle pulse.
- R9: A request is judged against the protect code held in its own cycle. A status write in the same cycle takes effect only for later requests.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low, asynchronous |
| wp_pin | input | 1 | Write-protect pin level (low enables the lock bit) |
| sts_wr | input | 1 | Status-write strobe |
| sts_wdata | input | 4 | [2:0] new protect code, [3] new lock bit |
| pe_req | input | 1 | Program/erase request strobe |
| pe_addr | input | 22 | Byte address of the program/erase request |
| ce_req | input | 1 | Chip-erase request strobe |
| prot_code | output | 3 | Current protect code |
| lock_bit | output | 1 | Current lock bit |
| pe_grant | output | 1 | Program/erase allowed pulse |
| pe_deny | output | 1 | Program/erase rejected pulse |
| ce_grant | output | 1 | Chip erase allowed pulse |
| ce_deny | output | 1 | Chip erase rejected pulse |
| sts_rej | output | 1 | Status write rejected pulse |

## Verification
For every nonzero code, the region decode is probed with the last address below the boundary and the first address at it. This separates an off-by-one threshold or a wrong power of two from a correct decode. Codes 0 and 7 are probed at the two ends of the array.

The lock is exercised in four combinations of pin level and lock value. This tells apart a lock that wrongly ignores the pin, one that never freezes, and one that freezes without flagging. A status write issued in the same cycle as a request shows whether the decision uses the old code or the new one.

// File: rtl/flash_wp_unit.sv
module flash_wp_unit #(
  parameter int ADDR_W = 22,
  parameter int BLK_W  = 6,
  parameter int CODE_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wp_pin,
  input  logic              sts_wr,
  input  logic [CODE_W:0]   sts_wdata,
  input  logic              pe_req,
  input  logic [ADDR_W-1:0] pe_addr,
  input  logic              ce_req,
  output logic [CODE_W-1:0] prot_code,
  output logic              lock_bit,
  output logic              pe_grant,
  output logic              pe_deny,
  output logic              ce_grant,
  output logic              ce_deny,
  output logic              sts_rej
);
  localparam int CNT_W = BLK_W + 1;
  localparam logic [CNT_W-1:0] NBLK = CNT_W'(1) << BLK_W;

  logic [CODE_W-1:0] code_q;
  logic              lock_q;
  logic [BLK_W-1:0]  blk;
  logic [CNT_W-1:0]  span;
  logic [CNT_W-1:0]  thr;
  logic              hit;
  logic              frozen;
  logic              code_zero;

  assign blk       = pe_addr[ADDR_W-1 -: BLK_W];
  assign code_zero = (code_q == '0);
  assign span      = CNT_W'(1) << (code_q - CODE_W'(1));
  assign thr       = NBLK - span;
  assign hit       = !code_zero && ({1'b0, blk} >= thr);
  assign frozen    = !wp_pin && lock_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '1;
      lock_q <= 1'b0;
    end else if (sts_wr && !frozen) begin
      code_q <= sts_wdata[CODE_W-1:0];
      lock_q <= sts_wdata[CODE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pe_grant <= 1'b0;
      pe_deny  <= 1'b0;
      ce_grant <= 1'b0;
      ce_deny  <= 1'b0;
      sts_rej  <= 1'b0;
    end else begin
      pe_grant <= pe_req && !hit;
      pe_deny  <= pe_req && hit;
      ce_grant <= ce_req && code_zero;
      ce_deny  <= ce_req && !code_zero;
      sts_rej  <= sts_wr && frozen;
    end
  end

  assign prot_code = code_q;
  assign lock_bit  = lock_q;
endmodule

// File: rtl/wp_unit_chk.sv
module wp_unit_chk #(
  parameter int CODE_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wp_pin,
  input logic              sts_wr,
  input logic [CODE_W:0]   sts_wdata,
  input logic              pe_req,
  input logic              ce_req,
  input logic [CODE_W-1:0] prot_code,
  input logic              lock_bit,
  input logic              pe_grant,
  input logic              pe_deny,
  input logic              ce_grant,
  input logic              ce_deny,
  input logic              sts_rej
);
  p_one_answer_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pe_req |=> (pe_grant ^ pe_deny));
  p_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !pe_req |=> !(pe_grant || pe_deny));
  p_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_req && prot_code == '0) |=> pe_grant);
  p_closed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pe_req && prot_code == '1) |=> pe_deny);
  p_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && (wp_pin || !lock_bit)) |=>
      (prot_code == $past(sts_wdata[CODE_W-1:0]) && lock_bit == $past(sts_wdata[CODE_W]) && !sts_rej));
  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && !wp_pin && lock_bit) |=> ($stable(prot_code) && $stable(lock_bit) && sts_rej));
  p_no_rej_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !sts_wr |=> !sts_rej);
  p_chip_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ce_req |=> ((ce_grant == $past(prot_code == '0)) && (ce_deny != ce_grant)));
  p_chip_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_req |=> !(ce_grant || ce_deny));
endmodule

bind flash_wp_unit wp_unit_chk #(.CODE_W(CODE_W)) u_chk (.*);

// File: tb/sim_flash_wp_unit.sv
`timescale 1ns/1ps
module sim_flash_wp_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wp_pin = 1'b1;
  logic        sts_wr = 1'b0;
  logic [3:0]  sts_wdata = '0;
  logic        pe_req = 1'b0;
  logic [21:0] pe_addr = '0;
  logic        ce_req = 1'b0;
  logic [2:0]  prot_code;
  logic        lock_bit, pe_grant, pe_deny, ce_grant, ce_deny, sts_rej;

  int nvec = 0;
  int nerr = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  flash_wp_unit u0 (.*);

  // {code, address, expected deny}
  localparam logic [25:0] VEC [15] = '{
    {3'd0, 22'h3FFFFF, 1'b0}, {3'd1, 22'h3EFFFF, 1'b0}, {3'd1, 22'h3F0000, 1'b1},
    {3'd2, 22'h3DFFFF, 1'b0}, {3'd2, 22'h3E0000, 1'b1}, {3'd3, 22'h3BFFFF, 1'b0},
    {3'd3, 22'h3C0000, 1'b1}, {3'd4, 22'h37FFFF, 1'b0}, {3'd4, 22'h380000, 1'b1},
    {3'd5, 22'h2FFFFF, 1'b0}, {3'd5, 22'h300000, 1'b1}, {3'd6, 22'h1FFFFF, 1'b0},
    {3'd6, 22'h200000, 1'b1}, {3'd7, 22'h000000, 1'b1}, {3'd0, 22'h000000, 1'b0}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nvec++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic sts_write(input logic [3:0] d, input logic wp);
    @(negedge clk);
    wp_pin = wp; sts_wr = 1'b1; sts_wdata = d;
    @(negedge clk);
    sts_wr = 1'b0;
  endtask

  task automatic pe_issue(input logic [21:0] a);
    @(negedge clk);
    pe_req = 1'b1; pe_addr = a;
    @(negedge clk);
    pe_req = 1'b0;
  endtask

  task automatic ce_issue();
    @(negedge clk);
    ce_req = 1'b1;
    @(negedge clk);
    ce_req = 1'b0;
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 code in reset", 8'(prot_code), 8'h7);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 code", 8'(prot_code), 8'h7);
    chk("R1 lock", 8'(lock_bit), 8'h0);
    chk("R1 pulses", {3'b0, pe_grant, pe_deny, ce_grant, ce_deny, sts_rej}, 8'h0);

    for (int i = 0; i < 15; i++) begin
      sts_write({1'b0, VEC[i][25:23]}, 1'b1);
      pe_issue(VEC[i][22:1]);
      chk("R2/R4 deny", 8'(pe_deny), 8'(VEC[i][0]));
      chk("R3 grant", 8'(pe_grant), 8'(!VEC[i][0]));
    end

    @(negedge clk);
    chk("R3 idle", {6'b0, pe_grant, pe_deny}, 8'h0);

    sts_write(4'b0101, 1'b1);
    chk("R5 code wp high", 8'(prot_code), 8'h5);
    sts_write(4'b0011, 1'b0);
    chk("R5 code wp low lock 0", 8'(prot_code), 8'h3);
    chk("R5 no rej", 8'(sts_rej), 8'h0);

    sts_write(4'b1010, 1'b1);
    chk("R5 lock set", {3'b0, lock_bit, 1'b0, prot_code}, 8'h12);
    sts_write(4'b0000, 1'b0);
    chk("R6 frozen code", 8'(prot_code), 8'h2);
    chk("R6 frozen lock", 8'(lock_bit), 8'h1);
    chk("R6 rej pulse", 8'(sts_rej), 8'h1);
    @(negedge clk);
    chk("R6 rej one cycle", 8'(sts_rej), 8'h0);
    pe_issue(22'h3E0000);
    chk("R6 still protected", 8'(pe_deny), 8'h1);

    sts_write(4'b0000, 1'b1);
    chk("R7 code", 8'(prot_code), 8'h0);
    chk("R7 lock cleared", 8'(lock_bit), 8'h0);
    chk("R7 no rej", 8'(sts_rej), 8'h0);

    ce_issue();
    chk("R8 grant code 0", {6'b0, ce_grant, ce_deny}, 8'h2);
    @(negedge clk);
    chk("R8 one cycle", {6'b0, ce_grant, ce_deny}, 8'h0);
    sts_write(4'b0011, 1'b1);
    ce_issue();
    chk("R8 deny code 3", {6'b0, ce_grant, ce_deny}, 8'h1);

    sts_write(4'b0111, 1'b1);
    @(negedge clk);
    sts_wr = 1'b1; sts_wdata = 4'b0000; pe_req = 1'b1; pe_addr = 22'h000000;
    @(negedge clk);
    sts_wr = 1'b0; pe_req = 1'b0;
    chk("R9 old code used", {6'b0, pe_grant, pe_deny}, 8'h1);
    chk("R9 new code stored", 8'(prot_code), 8'h0);
    pe_issue(22'h000000);
    chk("R9 later grant", {6'b0, pe_grant, pe_deny}, 8'h2);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule